// File: doc/BRIEF.md
# Cache Miss Type Classifier

This block models the tag side of a tiny data cache with four block frames of four bytes each, sixteen bytes in total. It labels every access as a hit or as one of three kinds of miss. A stream of byte addresses, each marked as a read or a write, arrives on a valid/ready handshake. The handshake is always ready, so one access is taken every cycle. One cycle after an access is taken, the block returns its verdict, and it keeps running saturating counters for each outcome. A parameter chooses the organisation of the modelled cache: direct-mapped, 2-way set-associative or fully associative. Replacement inside a set is least-recently-used, and writes allocate exactly like reads. The block models no data storage and no memory timing.

Two structures sort the misses. The first is a record of every block that has ever been touched. The second is a shadow fully associative LRU cache with the same four frames, updated on every access. A miss to a block that was never touched before is compulsory. Any other miss is a capacity miss if the shadow cache also misses, and a conflict miss if the shadow cache hits. The block is meant for measuring how a reference pattern behaves under each organisation.

Top module: `miss_classifier`

## Requirements
- R1: After reset `rsp_valid` is 0, all five counters read 0 and the first-touch record is empty, so the first access to any block is reported as compulsory.
- R2: The block address is the byte address shifted right by two. Two byte addresses that differ only in their two low bits name the same block.
- R3: `req_ready` is always 1. For an access taken at a clock edge, `rsp_valid` and the verdict appear after that edge and stay until the next edge. `rsp_valid` is 0 after a cycle with no access.
- R4: `rsp_kind` uses the encoding 0 = hit, 1 = compulsory, 2 = capacity, 3 = conflict, and `rsp_hit` is 1 exactly when `rsp_kind` is 0. The set index is the low block-address bits: two bits when MODE=0 (direct-mapped), one bit when MODE=1 (2-way), none when MODE=2 (fully associative).
- R5: A miss in a full set evicts the least recently used block of that set. Hits and misses both make the touched block the most recently used.
- R6: A write is treated like a read. A write miss allocates the block, so a later access to it can hit.
- R7: A miss to a block never accessed since reset is compulsory (kind 1).
- R8: A miss to a previously accessed block is a capacity miss (kind 2) when a 4-frame fully associative LRU cache fed the same stream would also miss.
- R9: A miss to a previously accessed block that the fully associative shadow would have hit is a conflict miss (kind 3). It never occurs with MODE=2.
- R10: `cnt_access` counts taken accesses. `cnt_hit`, `cnt_comp`, `cnt_cap` and `cnt_conf` count the verdicts of each kind. The counters update at the same edge as the verdict.
- R11: Each counter saturates at 65535 and then holds that value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Access offered |
| req_ready | output | 1 | Access accepted (always 1) |
| req_addr | input | ADDR_W | Byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| rsp_valid | output | 1 | Verdict valid |
| rsp_hit | output | 1 | Access hit |
| rsp_kind | output | 2 | 0 hit, 1 compulsory, 2 capacity, 3 conflict |
| cnt_access | output | CNT_W | Accesses taken |
| cnt_hit | output | CNT_W | Hits |
| cnt_comp | output | CNT_W | Compulsory misses |
| cnt_cap | output | CNT_W | Capacity misses |
| cnt_conf | output | CNT_W | Conflict misses |

## Verification
The hardest verdict to reach is the conflict miss. It needs a block that is still resident in the shadow fully associative cache but has been pushed out of its own set in the main cache. It therefore depends on the recency history of two structures at once. The stimulus reaches it with directed sequences that alternate two blocks mapping to the same set, and with a long random stream confined to sixteen blocks, where such overlaps happen often. Three instances, one per organisation, see the same stream, so the same history is judged under each organisation. Saturation is reached by a final run of more than 65535 back-to-back hits.

// File: rtl/mc_pkg.sv
package mc_pkg;
  localparam int BLK_OFF = 2;
  localparam int FRAMES  = 4;

  typedef enum logic [1:0] {
    KIND_HIT  = 2'd0,
    KIND_COMP = 2'd1,
    KIND_CAP  = 2'd2,
    KIND_CONF = 2'd3
  } kind_e;

  function automatic int sets_for_mode(input int mode);
    return (mode == 0) ? FRAMES : (mode == 1) ? FRAMES / 2 : 1;
  endfunction

  function automatic kind_e classify(input logic main_hit, input logic seen,
                                     input logic shadow_hit);
    if (main_hit)    return KIND_HIT;
    if (!seen)       return KIND_COMP;
    if (!shadow_hit) return KIND_CAP;
    return KIND_CONF;
  endfunction
endpackage

// File: rtl/lru_tags.sv
module lru_tags #(
  parameter int SETS = 2,
  parameter int WAYS = 2,
  parameter int BA_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [BA_W-1:0] blk,
  output logic            hit
);
  localparam int FR    = SETS * WAYS;
  localparam int SET_W = (SETS > 1) ? $clog2(SETS) : 1;
  localparam int AGE_W = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam int WAY_W = AGE_W;

  logic [FR-1:0]    valid_q;
  logic [BA_W-1:0]  tag_q [FR];
  logic [AGE_W-1:0] age_q [FR];

  logic [SET_W-1:0] set_idx;
  int               base;
  logic [WAYS-1:0]  way_hit;
  logic [WAY_W-1:0] hit_way, vic_way, use_way;
  logic [AGE_W-1:0] use_age;

  always_comb begin
    set_idx = SET_W'(blk) & SET_W'(SETS - 1);
    base    = int'(set_idx) * WAYS;
    way_hit = '0;
    hit_way = '0;
    vic_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (valid_q[base + w] && tag_q[base + w] == blk) begin
        way_hit[w] = 1'b1;
        hit_way    = WAY_W'(w);
      end
      if (age_q[base + w] == AGE_W'(WAYS - 1)) vic_way = WAY_W'(w);
    end
    hit     = |way_hit;
    use_way = hit ? hit_way : vic_way;
    use_age = age_q[base + int'(use_way)];
  end

  // Ages start as a permutation, so never-filled frames stay the oldest.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      for (int f = 0; f < FR; f++) begin
        tag_q[f] <= '0;
        age_q[f] <= AGE_W'(f % WAYS);
      end
    end else if (en) begin
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_W'(w) == use_way) begin
          valid_q[base + w] <= 1'b1;
          tag_q[base + w]   <= blk;
          age_q[base + w]   <= '0;
        end else if (age_q[base + w] < use_age) begin
          age_q[base + w] <= age_q[base + w] + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/first_touch.sv
module first_touch #(
  parameter int BA_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [BA_W-1:0] blk,
  output logic            seen
);
  localparam int BLOCKS = 1 << BA_W;
  logic [BLOCKS-1:0] touched_q;

  assign seen = touched_q[blk];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  touched_q      <= '0;
    else if (en) touched_q[blk] <= 1'b1;
  end
endmodule

// File: rtl/sat_counter.sv
module sat_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] value
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   value <= '0;
    else if (inc && value != '1)  value <= value + 1'b1;
  end
endmodule

// File: rtl/miss_classifier.sv
module miss_classifier
  import mc_pkg::*;
#(
  parameter int MODE   = 1,
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [1:0]        rsp_kind,
  output logic [CNT_W-1:0]  cnt_access,
  output logic [CNT_W-1:0]  cnt_hit,
  output logic [CNT_W-1:0]  cnt_comp,
  output logic [CNT_W-1:0]  cnt_cap,
  output logic [CNT_W-1:0]  cnt_conf
);
  localparam int BA_W  = ADDR_W - BLK_OFF;
  localparam int SETS  = sets_for_mode(MODE);
  localparam int WAYS  = FRAMES / SETS;
  localparam int NCNT  = 5;

  function automatic logic [BA_W-1:0] block_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:BLK_OFF];
  endfunction

  logic [BA_W-1:0] blk;
  logic            take;
  logic            main_hit, shadow_hit, seen_before;
  kind_e           kind_now;
  logic            write_seen;

  assign req_ready  = 1'b1;
  assign take       = req_valid;
  assign blk        = block_of(req_addr);
  // Writes allocate exactly like reads; the flag does not steer anything.
  assign write_seen = req_write;

  lru_tags #(.SETS(SETS), .WAYS(WAYS), .BA_W(BA_W)) u_main (
    .clk(clk), .rst_n(rst_n), .en(take), .blk(blk), .hit(main_hit));

  lru_tags #(.SETS(1), .WAYS(FRAMES), .BA_W(BA_W)) u_shadow (
    .clk(clk), .rst_n(rst_n), .en(take), .blk(blk), .hit(shadow_hit));

  first_touch #(.BA_W(BA_W)) u_seen (
    .clk(clk), .rst_n(rst_n), .en(take), .blk(blk), .seen(seen_before));

  assign kind_now = classify(main_hit, seen_before, shadow_hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_kind  <= 2'd0;
    end else begin
      rsp_valid <= take;
      if (take) begin
        rsp_hit  <= (kind_now == KIND_HIT);
        rsp_kind <= kind_now;
      end
    end
  end

  logic [NCNT-1:0]  inc_vec;
  logic [CNT_W-1:0] cnt_arr [NCNT];

  always_comb begin
    inc_vec[0] = take;
    inc_vec[1] = take && kind_now == KIND_HIT;
    inc_vec[2] = take && kind_now == KIND_COMP;
    inc_vec[3] = take && kind_now == KIND_CAP;
    inc_vec[4] = take && kind_now == KIND_CONF;
  end

  for (genvar i = 0; i < NCNT; i++) begin : g_cnt
    sat_counter #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .inc(inc_vec[i]), .value(cnt_arr[i]));
  end

  assign cnt_access = cnt_arr[0];
  assign cnt_hit    = cnt_arr[1];
  assign cnt_comp   = cnt_arr[2];
  assign cnt_cap    = cnt_arr[3];
  assign cnt_conf   = cnt_arr[4];

  logic unused_ok;
  assign unused_ok = write_seen;
endmodule

// File: rtl/mc_checker.sv
module mc_checker #(
  parameter int MODE  = 1,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             rsp_valid,
  input logic             rsp_hit,
  input logic [1:0]       rsp_kind,
  input logic [CNT_W-1:0] cnt_access,
  input logic [CNT_W-1:0] cnt_hit,
  input logic [CNT_W-1:0] cnt_comp,
  input logic [CNT_W-1:0] cnt_cap,
  input logic [CNT_W-1:0] cnt_conf,
  input logic             main_hit,
  input logic             shadow_hit,
  input logic             seen_before
);
  localparam logic [CNT_W-1:0] TOP = '1;

  assert_rsp_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  assert_rsp_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  assert_hit_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_hit == (rsp_kind == 2'd0)));
  assert_hit_implies_seen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (main_hit || shadow_hit)) |-> seen_before);
  assert_access_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && $past(cnt_access) != TOP) |-> cnt_access == $past(cnt_access) + 1'b1);
  assert_counts_sum_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_access != TOP) |->
      ((CNT_W+3)'(cnt_hit) + (CNT_W+3)'(cnt_comp) + (CNT_W+3)'(cnt_cap)
       + (CNT_W+3)'(cnt_conf)) == (CNT_W+3)'(cnt_access));
  assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_hit == TOP) |=> (cnt_hit == TOP));

  if (MODE == 2) begin : g_fa
    assert_fa_agree_R8: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> (main_hit == shadow_hit));
    assert_fa_no_conflict_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> rsp_kind != 2'd3);
  end
endmodule

bind miss_classifier mc_checker #(.MODE(MODE), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .rsp_valid(rsp_valid),
  .rsp_hit(rsp_hit), .rsp_kind(rsp_kind), .cnt_access(cnt_access),
  .cnt_hit(cnt_hit), .cnt_comp(cnt_comp), .cnt_cap(cnt_cap), .cnt_conf(cnt_conf),
  .main_hit(main_hit), .shadow_hit(shadow_hit), .seen_before(seen_before));

// File: tb/miss_classifier_test.sv
module miss_classifier_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic       req_valid = 1'b0;
  logic [7:0] req_addr  = '0;
  logic       req_write = 1'b0;
  logic       rdy [3];
  logic       rv [3];
  logic       rh [3];
  logic [1:0] rk [3];
  logic [15:0] ca [3], chh [3], cc [3], ccp [3], ccf [3];

  miss_classifier #(.MODE(1)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy[1]),
    .req_addr(req_addr), .req_write(req_write), .rsp_valid(rv[1]), .rsp_hit(rh[1]),
    .rsp_kind(rk[1]), .cnt_access(ca[1]), .cnt_hit(chh[1]), .cnt_comp(cc[1]),
    .cnt_cap(ccp[1]), .cnt_conf(ccf[1]));
  miss_classifier #(.MODE(0)) uut_dm (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy[0]),
    .req_addr(req_addr), .req_write(req_write), .rsp_valid(rv[0]), .rsp_hit(rh[0]),
    .rsp_kind(rk[0]), .cnt_access(ca[0]), .cnt_hit(chh[0]), .cnt_comp(cc[0]),
    .cnt_cap(ccp[0]), .cnt_conf(ccf[0]));
  miss_classifier #(.MODE(2)) uut_fa (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy[2]),
    .req_addr(req_addr), .req_write(req_write), .rsp_valid(rv[2]), .rsp_hit(rh[2]),
    .rsp_kind(rk[2]), .cnt_access(ca[2]), .cnt_hit(chh[2]), .cnt_comp(cc[2]),
    .cnt_cap(ccp[2]), .cnt_conf(ccf[2]));

  int total = 0;
  int bad = 0;
  bit done = 0;

  // Reference model: per-set recency lists, most recent first.
  int lst [3][4][4];
  int lcnt [3][4];
  bit seen [64];
  int exp_kind [3];
  int exp_cnt [3][5];

  function automatic int sets_of(input int m);
    return (m == 0) ? 4 : (m == 1) ? 2 : 1;
  endfunction

  function automatic int sat_add(input int v);
    return (v >= 65535) ? 65535 : v + 1;
  endfunction

  task automatic touch(input int m, input int b, output bit was_hit);
    int s, ways, pos;
    s = b % sets_of(m);
    ways = 4 / sets_of(m);
    pos = -1;
    for (int i = 0; i < lcnt[m][s]; i++) if (lst[m][s][i] == b) pos = i;
    was_hit = (pos >= 0);
    if (!was_hit) begin
      if (lcnt[m][s] < ways) lcnt[m][s]++;
      pos = lcnt[m][s] - 1;
    end
    for (int i = pos; i > 0; i--) lst[m][s][i] = lst[m][s][i-1];
    lst[m][s][0] = b;
  endtask

  task automatic model_access(input logic [7:0] a);
    int b;
    bit h [3];
    b = int'(a >> 2);
    for (int m = 2; m >= 0; m--) touch(m, b, h[m]);
    for (int m = 0; m < 3; m++) begin
      exp_kind[m] = h[m] ? 0 : !seen[b] ? 1 : !h[2] ? 2 : 3;
      exp_cnt[m][0] = sat_add(exp_cnt[m][0]);
      exp_cnt[m][1 + exp_kind[m]] = sat_add(exp_cnt[m][1 + exp_kind[m]]);
    end
    seen[b] = 1;
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input int m, input int got, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s mode=%0d got=%0d expected=%0d", req, what, m, got, expv);
    end
  endtask

  function automatic string kind_req(input int k);
    return (k == 0) ? "R4" : (k == 1) ? "R7" : (k == 2) ? "R8" : "R9";
  endfunction

  // Drive at a falling edge, check after the next rising edge.
  task automatic step(input bit v, input logic [7:0] a, input bit w, input string tag);
    string t;
    req_valid = v; req_addr = a; req_write = w;
    if (v) model_access(a);
    @(posedge clk);
    @(negedge clk);
    for (int m = 0; m < 3; m++) begin
      check(rdy[m] == 1'b1, "R3", "ready", m, int'(rdy[m]), 1);
      check(rv[m] == v, "R3", "rsp_valid", m, int'(rv[m]), int'(v));
      if (v) begin
        t = (tag != "") ? tag : kind_req(exp_kind[m]);
        check(int'(rk[m]) == exp_kind[m], t, "kind", m, int'(rk[m]), exp_kind[m]);
        check(rh[m] == (exp_kind[m] == 0), "R4", "hit", m, int'(rh[m]),
              int'(exp_kind[m] == 0));
      end
      check(int'(ca[m]) == exp_cnt[m][0], "R10", "cnt_access", m, int'(ca[m]), exp_cnt[m][0]);
      check(int'(chh[m]) == exp_cnt[m][1], "R11", "cnt_hit", m, int'(chh[m]), exp_cnt[m][1]);
      check(int'(cc[m]) == exp_cnt[m][2], "R10", "cnt_comp", m, int'(cc[m]), exp_cnt[m][2]);
      check(int'(ccp[m]) == exp_cnt[m][3], "R10", "cnt_cap", m, int'(ccp[m]), exp_cnt[m][3]);
      check(int'(ccf[m]) == exp_cnt[m][4], "R10", "cnt_conf", m, int'(ccf[m]), exp_cnt[m][4]);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    req_valid = 1'b0;
    for (int m = 0; m < 3; m++) begin
      for (int s = 0; s < 4; s++) lcnt[m][s] = 0;
      for (int k = 0; k < 5; k++) exp_cnt[m][k] = 0;
    end
    for (int b = 0; b < 64; b++) seen[b] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int m = 0; m < 3; m++) begin
      check(rv[m] == 1'b0, "R1", "rsp_valid after reset", m, int'(rv[m]), 0);
      check(ca[m] == 16'd0 && chh[m] == 16'd0 && cc[m] == 16'd0 &&
            ccp[m] == 16'd0 && ccf[m] == 16'd0, "R1", "counters after reset",
            m, int'(ca[m]), 0);
    end
  endtask

  initial begin
    int seed;
    logic [7:0] a;
    seed = 12345;
    void'($urandom(seed));
    do_reset();
    // R1/R2: first touch compulsory, same block via other byte offset hits
    step(1, 8'd0, 0, "R1");
    step(1, 8'd3, 0, "R2");
    step(1, 8'd4, 0, "R2");
    step(0, 8'd0, 0, "R3");
    // R6: write miss allocates, read then hits
    step(1, 8'd40, 1, "R6");
    step(1, 8'd41, 0, "R6");
    // R9: blocks 0 and 4 share set 0 in direct-mapped, conflict there
    do_reset();
    step(1, 8'd0, 0, "");
    step(1, 8'd16, 0, "");
    step(1, 8'd0, 0, "R9");
    step(1, 8'd16, 1, "R9");
    // R5: 2-way set 0 with blocks 0,4 then 0 again, 8 evicts 4 (LRU)
    step(1, 8'd0, 0, "R5");
    step(1, 8'd32, 0, "R5");
    step(1, 8'd0, 0, "R5");
    step(1, 8'd16, 0, "R5");
    // R8: five blocks cycled exceed four frames
    do_reset();
    for (int r = 0; r < 2; r++)
      for (int b = 0; b < 5; b++) step(1, 8'(b * 4), 0, (r == 1) ? "R8" : "");
    // array copy pattern: variable at 0, array at 4..20
    do_reset();
    for (int i = 0; i < 4; i++) begin
      step(1, 8'd0, 0, "");
      step(1, 8'(4 + 4 * i), 0, "");
      step(1, 8'(12 + 4 * i), 1, "");
      step(1, 8'd0, 1, "");
    end
    // random mix over sixteen blocks
    for (int n = 0; n < 3000; n++) begin
      a = 8'($urandom_range(0, 63));
      step(($urandom_range(0, 7) != 0), a, 1'($urandom_range(0, 1)), "");
    end
    // R11: saturate hit and access counters
    for (int n = 0; n < 66000; n++) step(1, 8'd0, 0, "");
    check(chh[1] == 16'hFFFF, "R11", "hit saturated", 1, int'(chh[1]), 65535);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog R3 got=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule